// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block turns a single host request into the bus cycles a raw NAND flash device expects. The host gives an operation code, a 24-bit page (row) address, a sub-page index and a flag that says whether the attached device has 2K pages or 512-byte pages. The sequencer then drives the command latch, address latch, write strobe, read strobe and the 8-bit data bus. It waits for the device's ready line before the first bus cycle. Any bytes read back from the device are handed to the host one at a time with a valid strobe.

Four operations are supported. Page read setup and page write setup send the opening command, the column bytes and the row bytes. A 2K read also gets its confirm command. Read-ID fetches the identifier and status bytes and appends a device-type flag byte. Bad-block marking programs one whole page with a fill byte. On 2K devices the sub-page index selects one of five fixed column offsets, and the last of these is the spare area. On 512-byte devices a single zero column byte is sent instead.

Internally a controller state machine (states IDLE, WAIT_RDY, CMD, COL, ROW, CONFIRM, FILL, PROG, ID_CMD, ID_ADDR, ID_READ, STAT_CMD, STAT_READ, FLAG, DONE) walks through each operation. IDLE moves to WAIT_RDY on an accepted start. WAIT_RDY moves to CMD, or to ID_CMD for read-ID, once ready is seen. CMD goes to COL and then ROW. After the third row byte, ROW branches to CONFIRM (2K read), to FILL (marking) or to DONE. FILL goes to PROG after the last fill byte. The read-ID path runs ID_CMD, ID_ADDR, ID_READ (four bytes), STAT_CMD, STAT_READ (two bytes), FLAG and then DONE. DONE always returns to IDLE. A bus-cycle engine with phases IDLE, LOW and HIGH carries out each single bus cycle. The controller advances one step each time the engine finishes a cycle.

Top module: `nand_seq`

## Requirements
- R1: A command cycle drives nand_cle=1 and nand_ale=0. An address cycle drives nand_ale=1 and nand_cle=0. A data cycle drives both low. Both are never high together.
- R2: After a start is accepted, no strobe (WE# or RE#) is driven until nand_rdy has been sampled high.
- R3: On a 2K device (dev_2k=1), two column bytes follow the opening command, low byte first. The column is 0x000, 0x210, 0x420, 0x630 or 0x830 for sub_idx 0, 1, 2, 3 and 4, and sub_idx 5 to 7 use 0x830.
- R4: On a 512-byte device (dev_2k=0), exactly one column byte of value 0x00 is sent in place of the two column bytes.
- R5: After the column byte(s), three row bytes are sent: row[7:0], then row[15:8], then row[23:16].
- R6: op=0 (read setup) sends command 0x00, column, row, and then command 0x30 only when dev_2k=1. op=1 (write setup) sends command 0x80, column, row and nothing more.
- R7: op=2 (read-ID) sends command 0x90, one address byte 0x00, four read cycles, command 0x70 and two read cycles. Seven bytes are returned on rd_valid, and the seventh is {7'b0, dev_2k}.
- R8: op=3 (mark bad) sends command 0x80 with the column of sub_idx 3 whatever sub_idx holds, then the row, then 528 data cycles of 0xF0, then command 0x10.
- R9: Every WE# and RE# strobe is low for LOW_CYC cycles (default 2). nand_dq_out stays constant and nand_dq_oe stays high for the whole WE# low phase. The two strobes are never low together.
- R10: busy rises in the cycle after an accepted start and stays high until the last bus cycle ends. done is then high for exactly one cycle, with busy low in that cycle.
- R11: start is accepted only while busy and done are both low. A start at any other time launches no operation and leaves the running one unchanged.
- R12: Each read cycle returns the value on nand_dq_in in the last RE# low cycle. It appears as rd_data with rd_valid high for one cycle, in the first cycle of the RE# high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | Operation: 0 read setup, 1 write setup, 2 read-ID, 3 mark bad |
| row | input | 24 | Page (row) address |
| sub_idx | input | 3 | Sub-page index selecting the 2K column offset |
| dev_2k | input | 1 | 1 = 2K-page device, 0 = 512-byte-page device |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Returned byte valid |
| rd_data | output | 8 | Returned byte |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus driven value |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus sampled value |
| nand_rdy | input | 1 | Device ready (1) or busy (0) |

## Verification
busy is due in the first cycle after the accepted start. done is due in the cycle after the final strobe's high phase ends, and busy is already low there. A read byte shows up one cycle after its RE# low phase closes. The bench therefore drives inputs and samples outputs on the falling clock edge, and it checks busy, done and the one-cycle done width at exactly those cycles. Bus bytes are logged by a device model on each WE# rising edge, together with the latch-enable levels, and compared against an expected list built from the requirements. Strobe widths and data stability are measured cycle by cycle on the falling edge.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        CYC_CMD   = 2'd0,
        CYC_ADDR  = 2'd1,
        CYC_WDATA = 2'd2,
        CYC_RDATA = 2'd3
    } cyc_kind_e;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_WRITE    = 2'd1,
        OP_READ_ID  = 2'd2,
        OP_MARK_BAD = 2'd3
    } nand_op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_CMD,
        ST_COL,
        ST_ROW,
        ST_CONFIRM,
        ST_FILL,
        ST_PROG,
        ST_ID_CMD,
        ST_ID_ADDR,
        ST_ID_READ,
        ST_STAT_CMD,
        ST_STAT_READ,
        ST_FLAG,
        ST_DONE
    } ctrl_state_e;

    localparam logic [11:0] SUB_STRIDE = 12'h210;
    localparam logic [11:0] SPARE_COL  = 12'h830;
    localparam logic [2:0]  SPARE_SUB  = 3'd4;

    // Column offset of a sub-page on a 2K device; indices past the spare clamp to it.
    function automatic logic [11:0] sub_column(input logic [2:0] sub);
        logic [11:0] idx;
        idx = {9'd0, sub};
        if (sub >= SPARE_SUB)
            return SPARE_COL;
        else
            return idx * SUB_STRIDE;
    endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
    import nand_seq_pkg::*;
#(
    parameter int unsigned LOW_CYC  = 2,
    parameter int unsigned HIGH_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  cyc_kind_e kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] dq_in,
    output logic      idle,
    output logic      ack,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic [7:0] dq_out,
    output logic      dq_oe,
    output logic      rd_valid,
    output logic [7:0] rd_data
);

    localparam int unsigned PH_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int unsigned CW     = $clog2(PH_MAX + 1);
    localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

    phase_e        ph, ph_nx;
    logic [CW-1:0] cnt, cnt_nx;
    cyc_kind_e     kind_q;
    logic [7:0]    byte_q;
    logic          low_end;

    assign low_end = (ph == PH_LOW) && (cnt == LOW_LAST);

    always_comb begin
        ph_nx  = ph;
        cnt_nx = cnt;
        unique case (ph)
            PH_IDLE: begin
                if (go) begin
                    ph_nx  = PH_LOW;
                    cnt_nx = '0;
                end
            end
            PH_LOW: begin
                if (cnt == LOW_LAST) begin
                    ph_nx  = PH_HIGH;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            PH_HIGH: begin
                if (cnt == HIGH_LAST) begin
                    ph_nx  = PH_IDLE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            default: begin
                ph_nx  = PH_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            kind_q   <= CYC_CMD;
            byte_q   <= 8'h00;
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            ph       <= ph_nx;
            cnt      <= cnt_nx;
            rd_valid <= low_end && (kind_q == CYC_RDATA);
            if (ph == PH_IDLE && go) begin
                kind_q <= kind;
                byte_q <= wbyte;
            end
            if (low_end && kind_q == CYC_RDATA)
                rd_data <= dq_in;
        end
    end

    always_comb begin
        idle   = (ph == PH_IDLE);
        ack    = (ph == PH_HIGH) && (cnt == HIGH_LAST);
        cle    = (ph != PH_IDLE) && (kind_q == CYC_CMD);
        ale    = (ph != PH_IDLE) && (kind_q == CYC_ADDR);
        we_n   = !((ph == PH_LOW) && (kind_q != CYC_RDATA));
        re_n   = !((ph == PH_LOW) && (kind_q == CYC_RDATA));
        dq_oe  = (ph != PH_IDLE) && (kind_q != CYC_RDATA);
        dq_out = byte_q;
    end

    // Width tracker for the write strobe
    logic [CW:0] we_low_len;
    logic        we_was_low;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_len <= '0;
            we_was_low <= 1'b0;
        end else begin
            we_was_low <= !we_n;
            if (!we_n) we_low_len <= we_low_len + (CW+1)'(1);
            else       we_low_len <= '0;
        end
    end

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n)); // R9
    AST_DQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(dq_out) && dq_oe)); // R9
    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n && we_was_low) |-> (we_low_len == (CW+1)'(LOW_CYC))); // R9
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R12

endmodule

// File: rtl/nand_op_ctrl.sv
module nand_op_ctrl
    import nand_seq_pkg::*;
#(
    parameter logic [7:0]  CMD_READ      = 8'h00,
    parameter logic [7:0]  CMD_READ_CONF = 8'h30,
    parameter logic [7:0]  CMD_WRITE     = 8'h80,
    parameter logic [7:0]  CMD_PROGRAM   = 8'h10,
    parameter logic [7:0]  CMD_ID        = 8'h90,
    parameter logic [7:0]  CMD_STATUS    = 8'h70,
    parameter int unsigned FILL_LEN      = 528,
    parameter logic [7:0]  FILL_BYTE     = 8'hF0,
    parameter logic [2:0]  MARK_SUB      = 3'd3,
    parameter int unsigned ID_LEN        = 4,
    parameter int unsigned STAT_LEN      = 2,
    parameter int unsigned ROW_BYTES     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op,
    input  logic [8*ROW_BYTES-1:0] row,
    input  logic [2:0] sub,
    input  logic       dev_2k,
    input  logic       nand_rdy,
    input  logic       eng_idle,
    input  logic       eng_ack,
    output logic       go,
    output cyc_kind_e  kind,
    output logic [7:0] wbyte,
    output logic       busy,
    output logic       done,
    output logic       flag_valid,
    output logic [7:0] flag_byte
);

    localparam int unsigned CNT_MAX = (FILL_LEN > 8) ? FILL_LEN : 8;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(FILL_LEN - 1);
    localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_LEN - 1);
    localparam logic [CNT_W-1:0] STAT_LAST = CNT_W'(STAT_LEN - 1);
    localparam logic [CNT_W-1:0] ROW_LAST  = CNT_W'(ROW_BYTES - 1);

    ctrl_state_e          state, state_nx;
    logic [CNT_W-1:0]     cnt, cnt_nx;
    nand_op_e             op_q;
    logic [8*ROW_BYTES-1:0] row_q;
    logic [11:0]          col_q;
    logic                 is2k_q;
    logic [2:0]           sub_sel;

    assign sub_sel = (nand_op_e'(op) == OP_MARK_BAD) ? MARK_SUB : sub;

    // Next state: bus-cycle states advance on engine completion
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_WAIT_RDY;
            ST_WAIT_RDY: begin
                if (nand_rdy) begin
                    state_nx = (op_q == OP_READ_ID) ? ST_ID_CMD : ST_CMD;
                    cnt_nx   = '0;
                end
            end
            ST_CMD: if (eng_ack) state_nx = ST_COL;
            ST_COL: begin
                if (eng_ack) begin
                    if (!is2k_q || cnt == CNT_W'(1)) begin
                        state_nx = ST_ROW;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end
            end
            ST_ROW: begin
                if (eng_ack) begin
                    if (cnt == ROW_LAST) begin
                        cnt_nx = '0;
                        unique case (op_q)
                            OP_READ:     state_nx = is2k_q ? ST_CONFIRM : ST_DONE;
                            OP_MARK_BAD: state_nx = ST_FILL;
                            default:     state_nx = ST_DONE;
                        endcase
                    end else begin
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end
            end
            ST_CONFIRM: if (eng_ack) state_nx = ST_DONE;
            ST_FILL: begin
                if (eng_ack) begin
                    if (cnt == FILL_LAST) begin
                        state_nx = ST_PROG;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end
            end
            ST_PROG:    if (eng_ack) state_nx = ST_DONE;
            ST_ID_CMD:  if (eng_ack) state_nx = ST_ID_ADDR;
            ST_ID_ADDR: begin
                if (eng_ack) begin
                    state_nx = ST_ID_READ;
                    cnt_nx   = '0;
                end
            end
            ST_ID_READ: begin
                if (eng_ack) begin
                    if (cnt == ID_LAST) begin
                        state_nx = ST_STAT_CMD;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end
            end
            ST_STAT_CMD: if (eng_ack) state_nx = ST_STAT_READ;
            ST_STAT_READ: begin
                if (eng_ack) begin
                    if (cnt == STAT_LAST) begin
                        state_nx = ST_FLAG;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end
            end
            ST_FLAG: state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            op_q   <= OP_READ;
            row_q  <= '0;
            col_q  <= '0;
            is2k_q <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (state == ST_IDLE && start) begin
                op_q   <= nand_op_e'(op);
                row_q  <= row;
                col_q  <= sub_column(sub_sel);
                is2k_q <= dev_2k;
            end
        end
    end

    // Outputs
    always_comb begin
        go         = 1'b0;
        kind       = CYC_CMD;
        wbyte      = 8'h00;
        busy       = 1'b1;
        done       = 1'b0;
        flag_valid = 1'b0;
        flag_byte  = {7'd0, is2k_q};
        unique case (state)
            ST_IDLE:     busy = 1'b0;
            ST_WAIT_RDY: ;
            ST_CMD: begin
                go    = eng_idle;
                wbyte = (op_q == OP_READ) ? CMD_READ : CMD_WRITE;
            end
            ST_COL: begin
                go    = eng_idle;
                kind  = CYC_ADDR;
                if (is2k_q)
                    wbyte = (cnt == '0) ? col_q[7:0] : {4'h0, col_q[11:8]};
            end
            ST_ROW: begin
                go    = eng_idle;
                kind  = CYC_ADDR;
                wbyte = row_q[8*cnt[1:0] +: 8];
            end
            ST_CONFIRM: begin
                go    = eng_idle;
                wbyte = CMD_READ_CONF;
            end
            ST_FILL: begin
                go    = eng_idle;
                kind  = CYC_WDATA;
                wbyte = FILL_BYTE;
            end
            ST_PROG: begin
                go    = eng_idle;
                wbyte = CMD_PROGRAM;
            end
            ST_ID_CMD: begin
                go    = eng_idle;
                wbyte = CMD_ID;
            end
            ST_ID_ADDR: begin
                go    = eng_idle;
                kind  = CYC_ADDR;
            end
            ST_ID_READ, ST_STAT_READ: begin
                go    = eng_idle;
                kind  = CYC_RDATA;
            end
            ST_STAT_CMD: begin
                go    = eng_idle;
                wbyte = CMD_STATUS;
            end
            ST_FLAG:  flag_valid = 1'b1;
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // Tracks whether ready has been sampled since the request was taken
    logic rdy_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 rdy_seen <= 1'b0;
        else if (state == ST_IDLE)                  rdy_seen <= 1'b0;
        else if (state == ST_WAIT_RDY && nand_rdy)  rdy_seen <= 1'b1;
    end

    AST_GO_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n) go |-> rdy_seen); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (busy || done)) |=> ($stable(op_q) && $stable(row_q) && $stable(col_q))); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R10
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> (cnt <= FILL_LAST)); // R8
    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy); // R10

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int unsigned LOW_CYC       = 2,
    parameter int unsigned HIGH_CYC      = 2,
    parameter logic [7:0]  CMD_READ      = 8'h00,
    parameter logic [7:0]  CMD_READ_CONF = 8'h30,
    parameter logic [7:0]  CMD_WRITE     = 8'h80,
    parameter logic [7:0]  CMD_PROGRAM   = 8'h10,
    parameter logic [7:0]  CMD_ID        = 8'h90,
    parameter logic [7:0]  CMD_STATUS    = 8'h70,
    parameter int unsigned FILL_LEN      = 528,
    parameter logic [7:0]  FILL_BYTE     = 8'hF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [23:0] row,
    input  logic [2:0]  sub_idx,
    input  logic        dev_2k,
    output logic        busy,
    output logic        done,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rdy
);

    logic       eng_go, eng_idle, eng_ack, eng_rd_valid, flag_valid;
    cyc_kind_e  eng_kind;
    logic [7:0] eng_wbyte, eng_rd_data, flag_byte;

    nand_op_ctrl #(
        .CMD_READ      (CMD_READ),
        .CMD_READ_CONF (CMD_READ_CONF),
        .CMD_WRITE     (CMD_WRITE),
        .CMD_PROGRAM   (CMD_PROGRAM),
        .CMD_ID        (CMD_ID),
        .CMD_STATUS    (CMD_STATUS),
        .FILL_LEN      (FILL_LEN),
        .FILL_BYTE     (FILL_BYTE),
        .MARK_SUB      (3'd3),
        .ID_LEN        (4),
        .STAT_LEN      (2),
        .ROW_BYTES     (3)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op         (op),
        .row        (row),
        .sub        (sub_idx),
        .dev_2k     (dev_2k),
        .nand_rdy   (nand_rdy),
        .eng_idle   (eng_idle),
        .eng_ack    (eng_ack),
        .go         (eng_go),
        .kind       (eng_kind),
        .wbyte      (eng_wbyte),
        .busy       (busy),
        .done       (done),
        .flag_valid (flag_valid),
        .flag_byte  (flag_byte)
    );

    nand_bus_cycle #(
        .LOW_CYC  (LOW_CYC),
        .HIGH_CYC (HIGH_CYC)
    ) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (eng_go),
        .kind     (eng_kind),
        .wbyte    (eng_wbyte),
        .dq_in    (nand_dq_in),
        .idle     (eng_idle),
        .ack      (eng_ack),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .dq_out   (nand_dq_out),
        .dq_oe    (nand_dq_oe),
        .rd_valid (eng_rd_valid),
        .rd_data  (eng_rd_data)
    );

    // The flag byte state follows the last read cycle's completion, so the two sources never overlap
    assign rd_valid = eng_rd_valid | flag_valid;
    assign rd_data  = flag_valid ? flag_byte : eng_rd_data;

    AST_RD_SOURCES: assert property (@(posedge clk) disable iff (!rst_n) !(eng_rd_valid && flag_valid)); // R7

endmodule

// File: tb/tb_nand_seq.sv
`timescale 1ns/1ps
module tb_nand_seq;

    localparam int LOWC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [23:0] row = 24'd0;
    logic [2:0]  sub_idx = 3'd0;
    logic        dev_2k = 1'b0;
    logic        busy, done, rd_valid;
    logic [7:0]  rd_data;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rdy = 1'b1;

    always #2.5 clk = ~clk;

    nand_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .row(row), .sub_idx(sub_idx),
        .dev_2k(dev_2k), .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rdy(nand_rdy)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Device model and bus log
    logic [1:0] log_k [600];
    logic [7:0] log_b [600];
    int         log_n = 0;
    logic [1:0] exp_k [600];
    logic [7:0] exp_b [600];
    int         exp_n = 0;
    logic [7:0] rd_log [16];
    int         rd_n = 0;
    int         re_cnt = 0;
    int         done_cnt = 0;
    int         mode = 0;
    int         rk = 0;
    logic [7:0] id_b [4];
    logic [7:0] st_b [2];
    int         we_run = 0, re_run = 0, bad_w = 0, bad_dq = 0;
    logic [7:0] dq_first = 8'h00;

    assign nand_dq_in = (mode == 1) ? id_b[rk[1:0]] : (mode == 2) ? st_b[rk[0]] : 8'h00;

    always @(posedge nand_we_n) begin
        if (log_n < 600) begin
            log_k[log_n] = {nand_cle, nand_ale};
            log_b[log_n] = nand_dq_out;
        end
        log_n++;
        if (nand_cle && nand_dq_out == 8'h90) begin mode = 1; rk = 0; end
        else if (nand_cle && nand_dq_out == 8'h70) begin mode = 2; rk = 0; end
    end

    always @(posedge nand_re_n) begin
        rk++;
        re_cnt++;
    end

    always @(negedge clk) begin
        if (done) done_cnt++;
        if (rd_valid) begin
            if (rd_n < 16) rd_log[rd_n] = rd_data;
            rd_n++;
        end
        if (!nand_we_n) begin
            if (we_run == 0) dq_first = nand_dq_out;
            else if (nand_dq_out !== dq_first || !nand_dq_oe) bad_dq++;
            we_run++;
        end else begin
            if (we_run != 0 && we_run != LOWC) bad_w++;
            we_run = 0;
        end
        if (!nand_re_n) re_run++;
        else begin
            if (re_run != 0 && re_run != LOWC) bad_w++;
            re_run = 0;
        end
        if (!nand_we_n && !nand_re_n) bad_w++;
    end

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic push(input logic [1:0] k, input logic [7:0] b);
        exp_k[exp_n] = k;
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    // Expected write-side bus cycles, {cle,ale}: 10 command, 01 address, 00 data
    task automatic build_exp(input logic [1:0] o, input logic [23:0] r, input logic [2:0] s, input bit t2k);
        int ss, col;
        exp_n = 0;
        if (o == 2'd2) begin
            push(2'b10, 8'h90);
            push(2'b01, 8'h00);
            push(2'b10, 8'h70);
        end else begin
            push(2'b10, (o == 2'd0) ? 8'h00 : 8'h80);
            ss  = (o == 2'd3) ? 3 : ((s > 4) ? 4 : int'(s));
            col = (ss == 4) ? 'h830 : ss * 'h210;
            if (t2k) begin
                push(2'b01, col[7:0]);
                push(2'b01, col[15:8]);
            end else begin
                push(2'b01, 8'h00);
            end
            push(2'b01, r[7:0]);
            push(2'b01, r[15:8]);
            push(2'b01, r[23:16]);
            if (o == 2'd0 && t2k) push(2'b10, 8'h30);
            if (o == 2'd3) begin
                for (int i = 0; i < 528; i++) push(2'b00, 8'hF0);
                push(2'b10, 8'h10);
            end
        end
    endtask

    task automatic cmp_range(input int lo, input int hi, input string tag);
        int bad;
        bad = -1;
        for (int i = lo; i < hi; i++)
            if (bad < 0 && (i >= log_n || log_b[i] !== exp_b[i])) bad = i;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, $sformatf("%s byte %0d", tag, bad), (bad < log_n) ? int'(log_b[bad]) : -1, int'(exp_b[bad]));
    endtask

    task automatic run_op(input logic [1:0] o, input logic [23:0] r, input logic [2:0] s,
                          input bit t2k, input int rdy_dly, input bit poke);
        string optag;
        int ncol, guard, kbad;
        optag = (o == 2'd2) ? "R7" : (o == 2'd3) ? "R8" : "R6";
        build_exp(o, r, s, t2k);
        for (int i = 0; i < 4; i++) id_b[i] = 8'($urandom);
        for (int i = 0; i < 2; i++) st_b[i] = 8'($urandom);
        nand_rdy = (rdy_dly == 0);
        @(negedge clk);
        log_n = 0; rd_n = 0; re_cnt = 0; done_cnt = 0; bad_w = 0; bad_dq = 0; mode = 0;
        start = 1'b1; op = o; row = r; sub_idx = s; dev_2k = t2k;
        @(negedge clk);
        start = 1'b0; row = ~r; sub_idx = ~s; dev_2k = ~t2k; op = ~o;
        chk(busy === 1'b1, "R10 busy in cycle after start", int'(busy), 1);
        if (rdy_dly > 0) begin
            repeat (rdy_dly) @(negedge clk);
            chk(log_n == 0 && re_cnt == 0 && nand_we_n === 1'b1, "R2 no strobe before ready", log_n, 0);
            nand_rdy = 1'b1;
        end
        if (poke) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done !== 1'b1 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(done === 1'b1 && busy === 1'b0, "R10 busy low when done", int'(busy), 0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done lasts one cycle", int'(done), 0);
        repeat (30) @(negedge clk);
        chk(busy === 1'b0 && done_cnt == 1, "R11 single run, stray start ignored", done_cnt, 1);
        chk(log_n == exp_n, {optag, " write cycle count"}, log_n, exp_n);
        kbad = 0;
        for (int i = 0; i < exp_n && i < log_n; i++) if (log_k[i] !== exp_k[i]) kbad++;
        chk(kbad == 0, "R1 latch enables per cycle", kbad, 0);
        if (o == 2'd2) begin
            cmp_range(0, exp_n, "R7 id command bytes");
            chk(re_cnt == 6, "R7 read strobes", re_cnt, 6);
            chk(rd_n == 7, "R7 returned byte count", rd_n, 7);
            kbad = 0;
            for (int i = 0; i < 4; i++) if (rd_log[i] !== id_b[i]) kbad++;
            for (int i = 0; i < 2; i++) if (rd_log[4+i] !== st_b[i]) kbad++;
            chk(kbad == 0, "R12 captured read bytes", kbad, 0);
            chk(rd_log[6] === {7'd0, t2k}, "R7 type flag byte", int'(rd_log[6]), int'(t2k));
        end else begin
            ncol = t2k ? 2 : 1;
            cmp_range(0, 1, {optag, " opening command"});
            cmp_range(1, 1 + ncol, t2k ? "R3 column bytes" : "R4 column byte");
            cmp_range(1 + ncol, 4 + ncol, "R5 row bytes");
            cmp_range(4 + ncol, exp_n, {optag, " trailing cycles"});
        end
        chk(bad_w == 0, "R9 strobe low width", bad_w, 0);
        chk(bad_dq == 0, "R9 data held during write strobe", bad_dq, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && rd_valid === 1'b0, "R10 reset idle outputs", int'(busy), 0);
        chk(nand_we_n === 1'b1 && nand_re_n === 1'b1 && nand_cle === 1'b0 && nand_ale === 1'b0,
            "R1 reset bus idle", int'({nand_we_n, nand_re_n, nand_cle, nand_ale}), 'hC);

        run_op(2'd0, 24'h123456, 3'd1, 1'b1, 0, 1'b0);
        run_op(2'd0, 24'hABCDEF, 3'd4, 1'b1, 0, 1'b0);
        run_op(2'd0, 24'h00FF01, 3'd7, 1'b1, 0, 1'b0);
        run_op(2'd0, 24'h0A0B0C, 3'd2, 1'b0, 0, 1'b0);
        run_op(2'd1, 24'h765432, 3'd3, 1'b1, 5, 1'b0);
        run_op(2'd1, 24'h111111, 3'd0, 1'b0, 0, 1'b1);
        run_op(2'd2, 24'h000000, 3'd0, 1'b1, 0, 1'b1);
        run_op(2'd2, 24'h000000, 3'd0, 1'b0, 3, 1'b0);
        run_op(2'd3, 24'hC0FFEE, 3'd0, 1'b1, 0, 1'b0);
        run_op(2'd3, 24'h345678, 3'd6, 1'b0, 2, 1'b1);
        for (int n = 0; n < 16; n++) begin
            run_op(2'($urandom), 24'($urandom), 3'($urandom), 1'($urandom),
                   int'($urandom % 4), 1'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule